// File: doc/BRIEF.md
# Synchronous Serial Position Transmitter (Slave Side)

This block sits at the sensor end of a clock-driven serial position link. A host supplies the serial clock; the block answers on one data line. A parallel position word arrives on a valid/ready input. The block holds it in a frame register and, when the host clocks, shifts it out one bit per rising clock edge with the most significant bit first. The rising edge after the least significant bit drives the line low to mark the end of the word.

A quiet-time monitor in the system clock domain decides when a frame ends. Every serial clock edge restarts it. If the host clocks again before the monitor runs out, the frame register stays frozen and the same word is sent again from its most significant bit. Only after `TM_CYCLES` system cycles with no serial clock edge does the line return high (idle) and a waiting word move into the frame register.

The serial clock input must already be synchronised to `clk`. Input stream rules: a word is taken on any `clk` edge where `word_valid` and `word_ready` are both high. `word_ready` drops while a word is waiting for the next idle period. Offers made while it is low are not taken and have no effect, so the producer must hold its word until it sees ready.

Top module: `ssi_slave_tx`

## Requirements
- R1: After reset `sdata_o` is 1 and `word_ready` is 1. While the link is idle, `sdata_o` stays at 1.
- R2: A falling serial clock edge seen while idle starts a frame and freezes the frame register. `sdata_o` stays 1 until the first rising edge.
- R3: Rising edges 1 to `WORD_W` of a frame drive the word bits from bit `WORD_W-1` down to bit 0. Each bit appears after the first `clk` edge that samples `sclk_i` high.
- R4: Rising edge `WORD_W+1` drives `sdata_o` to 0, with the same one-cycle timing.
- R5: Let E be the `clk` edge that samples the last serial clock edge. `sdata_o` returns to 1 on the `TM_CYCLES`-th `clk` edge after E, and not before.
- R6: If serial clocking resumes before the timeout, the next rising edge after the end-of-word low bit drives the MSB of the same frozen word, and the whole word repeats.
- R7: A word taken while a frame is active is held. It becomes the transmitted word only after the timeout, and it does not alter the frame in progress.
- R8: `word_ready` is 0 while a word is waiting for the frame register. Words offered in that time are not taken and never reach the line.
- R9: While idle, a taken word enters the frame register on the next `clk` edge. If several words are taken while idle, the last one taken before the starting falling edge is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock from the host, already synchronised to `clk`; idles high |
| word_data | input | WORD_W | Parallel position word |
| word_valid | input | 1 | `word_data` is offered |
| word_ready | output | 1 | The block takes the offered word on this edge |
| sdata_o | output | 1 | Serial data line; high when idle |

## Verification
The serial clock is sampled once by `clk`. Each data bit and the end-of-word low bit therefore appear on `sdata_o` after the first `clk` edge that sees the rising level. The bench changes `sclk_i` at a falling `clk` edge and reads the line at the next falling edge. The timeout is due exactly `TM_CYCLES` edges after that sampling edge. The bench counts falling edges from the final rising drive and reads the line at count `TM_CYCLES` (still low) and at `TM_CYCLES+1` (high). `word_ready` is combinational from the holding state, so it is read at the same falling edge where the word is offered, and again one edge after the word is taken.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;

  // Edge events of the synchronised serial clock, one cycle wide.
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;

  // Link phase kept by the quiet-time monitor.
  typedef enum logic {
    LINK_IDLE = 1'b0,
    LINK_BUSY = 1'b1
  } link_phase_e;

endpackage

// File: rtl/ssi_edge_detect.sv
module ssi_edge_detect
  import ssi_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  output sclk_edge_t edge_o
);

  // Last sampled level; reset to the idle-high level so that no false
  // edge appears when reset is released.
  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk_i;
    end
  end

  always_comb begin
    edge_o.rise = sclk_i & ~sclk_prev;
    edge_o.fall = ~sclk_i & sclk_prev;
  end

endmodule

// File: rtl/ssi_timeout.sv
module ssi_timeout
  import ssi_tx_pkg::*;
#(
  parameter int TM_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sclk_edge_t edge_i,
  output logic       busy_o,
  output logic       start_o,
  output logic       expire_o
);

  localparam int QW = (TM_CYCLES < 2) ? 1 : $clog2(TM_CYCLES);
  localparam logic [QW-1:0] QUIET_LAST = QW'(TM_CYCLES - 1);

  link_phase_e phase;
  logic [QW-1:0] quiet;
  logic any_edge;

  assign any_edge = edge_i.rise | edge_i.fall;
  assign busy_o   = (phase == LINK_BUSY);
  assign start_o  = (phase == LINK_IDLE) & edge_i.fall;
  assign expire_o = (phase == LINK_BUSY) & ~any_edge & (quiet == QUIET_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= LINK_IDLE;
      quiet <= '0;
    end else begin
      unique case (phase)
        LINK_IDLE: begin
          quiet <= '0;
          if (edge_i.fall) phase <= LINK_BUSY;
        end
        LINK_BUSY: begin
          if (any_edge) begin
            quiet <= '0;
          end else if (quiet == QUIET_LAST) begin
            quiet <= '0;
            phase <= LINK_IDLE;
          end else begin
            quiet <= quiet + 1'b1;
          end
        end
        default: phase <= LINK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ssi_word_stage.sv
module ssi_word_stage #(
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic              load_en,
  output logic [WORD_W-1:0] frame_o,
  output logic              hold_full_o
);

  logic [WORD_W-1:0] hold_q;
  logic              hold_full;
  logic              take;
  logic              move;

  assign word_ready  = ~hold_full;
  assign take        = word_valid & word_ready;
  assign move        = load_en & hold_full;
  assign hold_full_o = hold_full;

  // One-deep holding slot between the stream input and the frame.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (take) begin
        hold_q    <= word_data;
        hold_full <= 1'b1;
      end else if (move) begin
        hold_full <= 1'b0;
      end
    end
  end

  // Frame register: changes only while the link is idle (or at the
  // timeout edge itself).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_o <= '0;
    end else if (move) begin
      frame_o <= hold_q;
    end
  end

endmodule

// File: rtl/ssi_frame_shifter.sv
module ssi_frame_shifter #(
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              start_i,
  input  logic              expire_i,
  input  logic              rise_i,
  input  logic [WORD_W-1:0] frame_i,
  output logic              sdata_o
);

  localparam int PW = $clog2(WORD_W + 1);
  localparam logic [PW-1:0] TOP_IDX = PW'(WORD_W - 1);
  localparam logic [PW-1:0] END_POS = PW'(WORD_W);

  logic [PW-1:0] pos;
  logic [PW-1:0] sel;

  assign sel = TOP_IDX - pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdata_o <= 1'b1;
      pos     <= '0;
    end else if (expire_i) begin
      sdata_o <= 1'b1;
      pos     <= '0;
    end else if (start_i) begin
      pos     <= '0;
    end else if (busy_i && rise_i) begin
      if (pos == END_POS) begin
        sdata_o <= 1'b0;
        pos     <= '0;
      end else begin
        sdata_o <= frame_i[sel];
        pos     <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ssi_slave_tx.sv
module ssi_slave_tx
  import ssi_tx_pkg::*;
#(
  parameter int WORD_W    = 13,
  parameter int TM_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              sdata_o
);

  sclk_edge_t        sclk_edge;
  logic              busy;
  logic              start;
  logic              expire;
  logic              load_en;
  logic              hold_full;
  logic [WORD_W-1:0] frame_word;

  // The frame may be refreshed while idle, except on the edge that
  // starts a frame, and at the timeout edge.
  assign load_en = (~busy & ~sclk_edge.fall) | expire;

  ssi_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk_i),
    .edge_o (sclk_edge)
  );

  ssi_timeout #(.TM_CYCLES(TM_CYCLES)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (sclk_edge),
    .busy_o   (busy),
    .start_o  (start),
    .expire_o (expire)
  );

  ssi_word_stage #(.WORD_W(WORD_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_data   (word_data),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .load_en     (load_en),
    .frame_o     (frame_word),
    .hold_full_o (hold_full)
  );

  ssi_frame_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy),
    .start_i  (start),
    .expire_i (expire),
    .rise_i   (sclk_edge.rise),
    .frame_i  (frame_word),
    .sdata_o  (sdata_o)
  );

endmodule

// File: rtl/ssi_tx_checker.sv
module ssi_tx_checker #(
  parameter int WORD_W    = 13,
  parameter int TM_CYCLES = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_i,
  input logic              sdata_o,
  input logic              busy,
  input logic [WORD_W-1:0] frame_word
);

  localparam int QW = $clog2(TM_CYCLES + 1);
  localparam logic [QW-1:0] QSAT = QW'(TM_CYCLES);

  // Independent count of clk edges since the serial clock last moved.
  logic          last_sclk;
  logic [QW-1:0] qc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_sclk <= 1'b1;
      qc        <= '0;
    end else begin
      last_sclk <= sclk_i;
      if (sclk_i != last_sclk) qc <= '0;
      else if (qc != QSAT)     qc <= qc + 1'b1;
    end
  end

  // R1: an idle link always shows a high data line.
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sdata_o);

  // R2: a start from idle leaves the line high on the following edge.
  assert_start_keeps_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && last_sclk && !sclk_i) |=> sdata_o);

  // R3 / R4: the line only falls to a data or end level after a rising serial edge.
  assert_low_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdata_o && $past(sdata_o)) |-> ($past(sclk_i) && !$past(sclk_i, 2)));

  // R5: a full quiet window forces the line back high.
  assert_timeout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (qc == QSAT) |-> sdata_o);

  // R7: the frame never changes while a frame stays active.
  assert_frame_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_word));

endmodule

bind ssi_slave_tx ssi_tx_checker #(
  .WORD_W    (WORD_W),
  .TM_CYCLES (TM_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_i     (sclk_i),
  .sdata_o    (sdata_o),
  .busy       (busy),
  .frame_word (frame_word)
);

// File: tb/tb_ssi_slave_tx.sv
`timescale 1ns/1ps
module tb_ssi_slave_tx;

  localparam int WORD_W    = 5;
  localparam int TM_CYCLES = 12;
  localparam int HP        = 3;   // serial half period in clk cycles
  localparam int PAUSE     = 5;   // gap between repeated bursts (< timeout)
  localparam int NWORDS    = 1 << WORD_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sclk = 1'b1;
  logic [WORD_W-1:0] word_data = '0;
  logic              word_valid = 1'b0;
  logic              word_ready;
  logic              sdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ssi_slave_tx #(.WORD_W(WORD_W), .TM_CYCLES(TM_CYCLES)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (sclk),
    .word_data  (word_data),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .sdata_o    (sdata)
  );

  function automatic int seq_word(input int i);
    return (i * 13 + 5) % NWORDS;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put_word(input int d);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = WORD_W'(d);
    while (!word_ready) @(negedge clk);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  // Offer a word mid-frame, then a second one while the slot is full.
  task automatic offer_word(input int d);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = WORD_W'(d);
    check("R8", int'(word_ready), 1);
    @(negedge clk);
    check("R8", int'(word_ready), 0);
    word_data = WORD_W'(~d);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic run_burst(input int w, input bit first, input bit offer,
                           input int nxt, input bit last, input string tag);
    @(negedge clk) sclk = 1'b0;
    @(negedge clk);
    if (first) check("R2", int'(sdata), 1);
    repeat (HP - 1) @(negedge clk);
    if (offer) offer_word(nxt);
    for (int k = 0; k < WORD_W; k++) begin
      @(negedge clk) sclk = 1'b1;
      @(negedge clk);
      check(tag, int'(sdata), (w >> (WORD_W - 1 - k)) & 1);
      repeat (HP - 1) @(negedge clk);
      @(negedge clk) sclk = 1'b0;
      repeat (HP) @(negedge clk);
    end
    @(negedge clk) sclk = 1'b1;
    if (!last) begin
      @(negedge clk);
      check("R4", int'(sdata), 0);
      repeat (HP - 1) @(negedge clk);
    end else begin
      for (int j = 1; j <= TM_CYCLES + 1; j++) begin
        @(negedge clk);
        if (j == 1)             check("R4", int'(sdata), 0);
        if (j == TM_CYCLES)     check("R5", int'(sdata), 0);
        if (j == TM_CYCLES + 1) check("R5", int'(sdata), 1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(sdata), 1);
    check("R1", int'(word_ready), 1);
    repeat (5) @(negedge clk);
    check("R1", int'(sdata), 1);

    // R9: two words taken while idle; the later one is sent.
    put_word(~seq_word(0) & (NWORDS - 1));
    put_word(seq_word(0));
    repeat (3) @(negedge clk);
    check("R1", int'(sdata), 1);

    for (int i = 0; i < NWORDS; i++) begin
      string tag;
      int w;
      w = seq_word(i);
      tag = (i == 0) ? "R9" : ((i % 2) == 1) ? "R7" : "R3";
      run_burst(w, 1'b1, (i < NWORDS - 1), seq_word(i + 1), 1'b0, tag);
      repeat (PAUSE) @(negedge clk);
      run_burst(w, 1'b0, 1'b0, 0, 1'b1, "R6");
      repeat (2) @(negedge clk);
      check("R1", int'(sdata), 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule